// File: doc/BRIEF.md
# Framebuffer Control and Interrupt Register File

This block is the control and status register file of a simple framebuffer controller. It is reached through a byte-addressed window of 32 bytes. A host writes a byte with a single-cycle write strobe. Read data follows the address combinationally.

The upper half of the window has three parts. There is a control byte whose top bit enables the vertical-sync interrupt. There is a status byte that carries a sticky interrupt-pending flag together with fixed identification bits. The rest is plain byte storage used for cursor and video control settings. The lower half of the window belongs to the palette and is not handled here: it reads as zero and ignores writes.

The scanout logic sends a single-cycle frame-end pulse. When the interrupt is enabled, that pulse sets the pending flag. The level interrupt output follows the pending flag. Software clears the flag by writing any value to the status byte.

Top module: `fbc_ctrl_regs`

## Requirements
- R1: While reset is held and right after it is released, `irq` is 0, the control byte (offset 0x10) reads 0x00, every storage byte (offsets 0x12 to 0x1F) reads 0x00 and status (offset 0x11) reads 0x61.
- R2: The control byte at offset 0x10 stores all 8 written bits and reads them back unchanged. Its bit 7 is the interrupt enable.
- R3: Offsets 0x12 through 0x1F are 14 independent read/write bytes. A write to one of them leaves the others unchanged.
- R4: A frame-end pulse in a cycle where control bit 7 is 1 sets the pending flag on that clock edge. `irq` is then 1 from the following cycle.
- R5: A frame-end pulse while control bit 7 is 0 leaves the pending flag and `irq` at 0.
- R6: A write to offset 0x11 clears the pending flag and lowers `irq`, whatever data byte is written. The written data never reaches any status bit.
- R7: A status read returns the pending flag in bit 7, ORed with the constant 0x61 (monitor sense 0x60 and colour board 0x01). All other bits are 0.
- R8: Offsets 0x00 through 0x0F read as 0x00, and writes to them change no register.
- R9: When a frame-end pulse with the interrupt enabled and a status write fall in the same cycle, the pending flag ends up set.
- R10: `irq` equals the pending flag (status bit 7) at all times.
- R11: Once set, the pending flag stays set until a status write or a reset. Clearing the interrupt enable does not clear it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; its release is synchronised inside the block |
| reg_addr | input | ADDR_W (5) | Byte offset within the register window |
| reg_wr | input | 1 | Write strobe, one byte per cycle |
| reg_wdata | input | DATA_W (8) | Write data |
| reg_rdata | output | DATA_W (8) | Read data for `reg_addr`, combinational |
| frame_end | input | 1 | Single-cycle end-of-frame pulse |
| irq | output | 1 | Level interrupt, high while the pending flag is set |

## Verification
The bench builds the block with its default parameters: a 5-bit address and 8-bit data. This gives the full 32-byte window. Every offset can be reached, including both ends of the storage range (0x12 and 0x1F) and the whole ignored lower half. Sweeping all offsets this way shows up decode slips at the 0x0F/0x10 and 0x11/0x12 boundaries. The 8-bit width lets the bench write all-ones and all-zeros patterns to status, which shows that written data never leaks into the fixed identification bits.

// File: rtl/fbc_regs_pkg.sv
package fbc_regs_pkg;
  // Byte offsets inside the register window
  localparam int unsigned CTRL_OFS  = 16;
  localparam int unsigned STAT_OFS  = 17;
  localparam int unsigned STORE_OFS = 18;
  // Bit positions and fixed status content
  localparam int unsigned IE_BIT    = 7;
  localparam int unsigned PEND_BIT  = 7;
  localparam logic [7:0]  SENSE_ID  = 8'h60;
  localparam logic [7:0]  COLOR_ID  = 8'h01;

  typedef enum logic [1:0] {
    SEL_NONE  = 2'd0,
    SEL_CTRL  = 2'd1,
    SEL_STAT  = 2'd2,
    SEL_STORE = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/fbc_addr_decode.sv
module fbc_addr_decode
  import fbc_regs_pkg::*;
#(
  parameter int unsigned ADDR_W    = 5,
  parameter int unsigned NUM_STORE = 14
) (
  input  logic [ADDR_W-1:0]    addr,
  input  logic                 wr,
  output reg_sel_e             sel,
  output logic [NUM_STORE-1:0] store_hit,
  output logic                 wr_ctrl,
  output logic                 wr_stat,
  output logic [NUM_STORE-1:0] wr_store
);
  always_comb begin
    sel = SEL_NONE;
    if (32'(addr) == CTRL_OFS)       sel = SEL_CTRL;
    else if (32'(addr) == STAT_OFS)  sel = SEL_STAT;
    else if (32'(addr) >= STORE_OFS) sel = SEL_STORE;
  end

  for (genvar i = 0; i < NUM_STORE; i++) begin : g_hit
    assign store_hit[i] = (32'(addr) == STORE_OFS + i);
    assign wr_store[i]  = wr & store_hit[i];
  end

  assign wr_ctrl = wr & (sel == SEL_CTRL);
  assign wr_stat = wr & (sel == SEL_STAT);
endmodule

// File: rtl/fbc_byte_store.sv
module fbc_byte_store #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [DATA_W-1:0] d,
  output logic [DATA_W-1:0] q
);
  logic [DATA_W-1:0] q_nx;

  always_comb begin
    q_nx = q;
    if (en) q_nx = d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_nx;
  end
endmodule

// File: rtl/fbc_irq_ctrl.sv
module fbc_irq_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic irq_en,
  input  logic frame_end,
  input  logic clr,
  output logic pend
);
  logic pend_nx;

  // a set in the same cycle as a clear wins
  always_comb begin
    pend_nx = pend;
    if (clr)                 pend_nx = 1'b0;
    if (frame_end && irq_en) pend_nx = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend <= 1'b0;
    else        pend <= pend_nx;
  end
endmodule

// File: rtl/fbc_ctrl_regs.sv
module fbc_ctrl_regs
  import fbc_regs_pkg::*;
#(
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              frame_end,
  output logic              irq
);
  localparam int unsigned WIN_BYTES = 1 << ADDR_W;
  localparam int unsigned NUM_STORE = WIN_BYTES - STORE_OFS;
  localparam logic [DATA_W-1:0] STAT_FIXED = DATA_W'(SENSE_ID | COLOR_ID);

  // reset synchroniser: asserts at once, releases on the clock
  logic [1:0] rst_sh;
  logic       rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sh <= 2'b00;
    else        rst_sh <= {rst_sh[0], 1'b1};
  end
  assign rst_ni = rst_sh[1];

  reg_sel_e             sel;
  logic [NUM_STORE-1:0] store_hit;
  logic                 wr_ctrl;
  logic                 wr_stat;
  logic [NUM_STORE-1:0] wr_store;

  fbc_addr_decode #(.ADDR_W(ADDR_W), .NUM_STORE(NUM_STORE)) u_dec (
    .addr      (reg_addr),
    .wr        (reg_wr),
    .sel       (sel),
    .store_hit (store_hit),
    .wr_ctrl   (wr_ctrl),
    .wr_stat   (wr_stat),
    .wr_store  (wr_store)
  );

  logic [DATA_W-1:0] ctrl_q;
  fbc_byte_store #(.DATA_W(DATA_W)) u_ctrl (
    .clk (clk), .rst_n (rst_ni), .en (wr_ctrl), .d (reg_wdata), .q (ctrl_q)
  );

  logic [DATA_W-1:0] store_q [NUM_STORE];
  for (genvar i = 0; i < NUM_STORE; i++) begin : g_store
    fbc_byte_store #(.DATA_W(DATA_W)) u_byte (
      .clk (clk), .rst_n (rst_ni), .en (wr_store[i]), .d (reg_wdata),
      .q   (store_q[i])
    );
  end

  logic ctrl_ie;
  logic pend;
  assign ctrl_ie = ctrl_q[IE_BIT];

  fbc_irq_ctrl u_irq (
    .clk       (clk),
    .rst_n     (rst_ni),
    .irq_en    (ctrl_ie),
    .frame_end (frame_end),
    .clr       (wr_stat),
    .pend      (pend)
  );

  assign irq = pend;

  logic [DATA_W-1:0] store_rd;
  always_comb begin
    store_rd = '0;
    for (int i = 0; i < NUM_STORE; i++)
      if (store_hit[i]) store_rd = store_q[i];
  end

  always_comb begin
    unique case (sel)
      SEL_CTRL:  reg_rdata = ctrl_q;
      SEL_STAT:  reg_rdata = STAT_FIXED | (DATA_W'(pend) << PEND_BIT);
      SEL_STORE: reg_rdata = store_rd;
      default:   reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/fbc_ctrl_regs_chk.sv
module fbc_ctrl_regs_chk #(
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              reg_wr,
  input logic [DATA_W-1:0] reg_rdata,
  input logic              frame_end,
  input logic              ctrl_ie,
  input logic              irq
);
  logic stat_wr;
  logic set_ev;
  assign stat_wr = reg_wr && (32'(reg_addr) == 17);
  assign set_ev  = frame_end && ctrl_ie;

  // R4
  irq_set_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    set_ev |=> irq);

  // R6
  irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (stat_wr && !set_ev) |=> !irq);

  // R11
  pend_sticky_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (irq && !stat_wr) |=> irq);

  // R5
  no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (!irq && !set_ev) |=> !irq);

  // R1
  always @(posedge clk) if (!rst_n) reset_low_chk: assert (!irq);

  // R10
  always @(negedge clk)
    if (rst_ni && 32'(reg_addr) == 17) stat_irq_chk: assert (reg_rdata[7] == irq);

  // R8
  always @(negedge clk)
    if (rst_ni && 32'(reg_addr) < 16) low_zero_chk: assert (reg_rdata == '0);
endmodule

bind fbc_ctrl_regs fbc_ctrl_regs_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .rst_ni    (rst_ni),
  .reg_addr  (reg_addr),
  .reg_wr    (reg_wr),
  .reg_rdata (reg_rdata),
  .frame_end (frame_end),
  .ctrl_ie   (ctrl_ie),
  .irq       (irq)
);

// File: tb/fbc_ctrl_regs_test.sv
module fbc_ctrl_regs_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] reg_addr = '0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       frame_end = 1'b0;
  logic       irq;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fbc_ctrl_regs uut (
    .clk (clk), .rst_n (rst_n), .reg_addr (reg_addr), .reg_wr (reg_wr),
    .reg_wdata (reg_wdata), .reg_rdata (reg_rdata), .frame_end (frame_end),
    .irq (irq)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic pulse_frame();
    @(negedge clk);
    frame_end = 1'b1;
    @(negedge clk);
    frame_end = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    chk("R1 irq in reset", {7'd0, irq}, 8'h00);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 irq after reset", {7'd0, irq}, 8'h00);
    rd(5'h10, d); chk("R1 ctrl", d, 8'h00);
    rd(5'h11, d); chk("R1 status", d, 8'h61);
    for (int a = 18; a < 32; a++) begin
      rd(5'(a), d); chk("R1 store", d, 8'h00);
    end
  endtask

  task automatic t_ctrl();
    logic [7:0] d;
    wr(5'h10, 8'hA5); rd(5'h10, d); chk("R2 ctrl A5", d, 8'hA5);
    wr(5'h10, 8'h5A); rd(5'h10, d); chk("R2 ctrl 5A", d, 8'h5A);
    wr(5'h10, 8'h00);
  endtask

  task automatic t_store();
    logic [7:0] d;
    for (int a = 18; a < 32; a++) wr(5'(a), 8'(a * 7 + 3));
    for (int a = 18; a < 32; a++) begin
      rd(5'(a), d); chk("R3 store pattern", d, 8'(a * 7 + 3));
    end
    wr(5'h12, 8'hFF);
    rd(5'h12, d); chk("R3 low end", d, 8'hFF);
    rd(5'h13, d); chk("R3 neighbour", d, 8'(19 * 7 + 3));
    wr(5'h1F, 8'h00);
    rd(5'h1F, d); chk("R3 high end", d, 8'h00);
    rd(5'h1E, d); chk("R3 neighbour hi", d, 8'(30 * 7 + 3));
  endtask

  task automatic t_disabled();
    logic [7:0] d;
    wr(5'h10, 8'h7F);
    pulse_frame();
    chk("R5 irq stays low", {7'd0, irq}, 8'h00);
    rd(5'h11, d); chk("R5 status", d, 8'h61);
  endtask

  task automatic t_set_clear();
    logic [7:0] d;
    wr(5'h10, 8'h80);
    pulse_frame();
    chk("R4 irq raised", {7'd0, irq}, 8'h01);
    rd(5'h11, d); chk("R7 status pending", d, 8'hE1);
    chk("R10 irq matches bit7", {7'd0, irq}, {7'd0, d[7]});
    wr(5'h11, 8'hFF);
    chk("R6 irq cleared FF", {7'd0, irq}, 8'h00);
    rd(5'h11, d); chk("R6 status after FF", d, 8'h61);
    pulse_frame();
    wr(5'h11, 8'h00);
    chk("R6 irq cleared 00", {7'd0, irq}, 8'h00);
    wr(5'h11, 8'h9E);
    rd(5'h11, d); chk("R6 data ignored", d, 8'h61);
  endtask

  task automatic t_sticky();
    logic [7:0] d;
    wr(5'h10, 8'h80);
    pulse_frame();
    wr(5'h10, 8'h00);
    repeat (5) @(negedge clk);
    chk("R11 still pending", {7'd0, irq}, 8'h01);
    rd(5'h11, d); chk("R11 status", d, 8'hE1);
    wr(5'h11, 8'h00);
    chk("R11 cleared", {7'd0, irq}, 8'h00);
  endtask

  task automatic t_collision();
    wr(5'h10, 8'h80);
    @(negedge clk);
    reg_addr = 5'h11; reg_wdata = 8'h00; reg_wr = 1'b1; frame_end = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; frame_end = 1'b0;
    chk("R9 set wins", {7'd0, irq}, 8'h01);
    wr(5'h11, 8'h00);
    chk("R9 later clear", {7'd0, irq}, 8'h00);
  endtask

  task automatic t_low_window();
    logic [7:0] d;
    wr(5'h10, 8'h3C);
    wr(5'h12, 8'h11);
    wr(5'h1F, 8'h22);
    for (int a = 0; a < 16; a++) wr(5'(a), 8'hFF);
    for (int a = 0; a < 16; a++) begin
      rd(5'(a), d); chk("R8 low reads zero", d, 8'h00);
    end
    rd(5'h10, d); chk("R8 ctrl untouched", d, 8'h3C);
    rd(5'h12, d); chk("R8 store lo untouched", d, 8'h11);
    rd(5'h1F, d); chk("R8 store hi untouched", d, 8'h22);
    rd(5'h11, d); chk("R8 status untouched", d, 8'h61);
  endtask

  task automatic t_reset_again();
    logic [7:0] d;
    wr(5'h10, 8'h80);
    pulse_frame();
    @(negedge clk); rst_n = 1'b0;
    #1 chk("R1 reset lowers irq", {7'd0, irq}, 8'h00);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(negedge clk);
    rd(5'h10, d); chk("R1 ctrl cleared", d, 8'h00);
    rd(5'h12, d); chk("R1 store cleared", d, 8'h00);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_ctrl();
    t_store();
    t_disabled();
    t_set_clear();
    t_sticky();
    t_collision();
    t_low_window();
    t_reset_again();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule